// File: doc/BRIEF.md
# Image Sensor Readout Timing Generator

This block produces the digital readout side of a megapixel image sensor without any analog content. It walks a physical pixel array (1312 columns by 1048 rows by default) in progressive-scan order and drives a 10-bit pixel bus together with a frame-active and a line-active qualifier. The pixel values come from a built-in synthetic pattern, so the block can stand in for a real sensor when bringing up a capture path.

The array has an optically black border on all four sides. It is wider on the left and top than on the right and bottom. In normal mode only a centred window (1280 x 1024 by default) is read out. That window sits a fixed number of pixels inside the active area. In raw mode the full physical array is read out, black border included. Horizontal and vertical blanking lengths are programmable through a small register write port. Every register write takes effect only when the next frame starts.

The block can free-run frame after frame, or wait in snapshot mode for a trigger level. In snapshot mode it first models an array reset phase, flags its completion with a one-cycle strobe, and then reads out one frame. A pixel clock follows the master clock in phase. An output-disable input releases all outputs to high impedance.

Top module: `img_readout_gen`

## Requirements
- R1: An active-low asynchronous reset clears all outputs to 0 and restores the defaults: horizontal blank HB_DEF, vertical blank VB_DEF, normal (windowed) mode and continuous readout. The first frame after reset uses these defaults.
- R2: In normal mode each frame carries WIN_H lines of exactly WIN_W pixels. The first pixel is physical row BLK_T+BORDER, column BLK_L+BORDER, and rows and columns then increase by one.
- R3: When bit 11 of the mode register (address 0x20) is 1, each frame carries all ROWS lines of COLS pixels, starting from physical row 0, column 0.
- R4: While line-active is high, pixel_data (bit 9 = MSB) equals BLACK_CODE for a pixel in the black border (column < BLK_L, column >= COLS-BLK_R, row < BLK_T or row >= ROWS-BLK_B). Otherwise it equals (row + column) mod 1024. While line-active is low, pixel_data is 0.
- R5: The horizontal blank register (address 0x05, value h) holds line-active low for max(h,1) cycles between consecutive lines of a frame.
- R6: In continuous mode, with v the vertical blank register (address 0x06) and L the line period (pixels per line plus max(h,1)) of the frame that just ended, frame-active stays low for v*L + 1 cycles between frames.
- R7: Frame-active rises one cycle before the first line-active of a frame and falls one cycle after the last line-active ends. Line-active is never high while frame-active is low.
- R8: A register write made during a frame leaves that frame's geometry and blanking unchanged. It applies from the next frame.
- R9: When bit 4 of the mode register is 1, no frame starts until the trigger input is high. The trigger is sampled at a clock edge. The strobe output is high for exactly one cycle, ARST_CYC cycles later, and frame-active rises in the cycle after the strobe. Only one frame follows each trigger.
- R10: pixel_clk is high while the master clock is high and low while it is low, also during blanking.
- R11: While out_dis is 1, pixel_clk, pixel_data, frame_act, line_act and expo_strobe are not driven. Once out_dis returns to 0 they are driven again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_dis | input | 1 | High releases all outputs to high impedance |
| trig | input | 1 | Snapshot trigger, level sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address (0x05, 0x06, 0x20) |
| wr_data | input | 16 | Register write data |
| pixel_clk | output | 1 | Pixel clock, in phase with clk |
| pixel_data | output | 10 | Pixel value, bit 9 is the MSB |
| frame_act | output | 1 | High across a frame of read-out lines |
| line_act | output | 1 | High while a line's pixels are on the bus |
| expo_strobe | output | 1 | One-cycle pulse at the end of the array reset phase |

## Verification
The bench builds the block with a 40 x 24 array and black borders of 4/2/3/3 (left/top/right/bottom). The border is 2, the window is 28 x 14, the blank fields are 6 and 4 bits wide, and the array reset phase lasts 6 cycles. With these values a full raw frame takes about a thousand cycles. Many frames therefore fit in the run, and the black code shows up on all four sides. Random blank values and mode switches, including blank values of 0, are written in the middle of frames. This checks that the blanking lengths follow the registers and that the geometry changes only at frame boundaries. Snapshot idling, the trigger-to-strobe delay and output release are exercised in directed phases.

// File: rtl/sro_pkg.sv
// Shared definitions for the image readout generator: scan states and
// register map. Assumes an 8-bit register address space.
package sro_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting to start a frame
        ST_ARST,   // snapshot array reset phase
        ST_LEAD,   // frame-active lead cycle
        ST_ROW,    // line readout plus horizontal blank
        ST_TAIL,   // frame-active tail cycle
        ST_VBL     // vertical blanking lines
    } scan_st_t;

    localparam logic [7:0] ADDR_HBLANK = 8'h05;
    localparam logic [7:0] ADDR_VBLANK = 8'h06;
    localparam logic [7:0] ADDR_MODE   = 8'h20;
    localparam int MODE_RAW_BIT  = 11;
    localparam int MODE_SNAP_BIT = 4;
endpackage

// File: rtl/sro_regs.sv
// Register file with per-frame shadow copies. Live registers take writes
// at any time; shadows are loaded only when the scan asserts latch (entry
// into a new frame). Assumes writes are single-cycle strobes.
module sro_regs #(
    parameter int HB_W   = 11,
    parameter int VB_W   = 11,
    parameter int HB_DEF = 32,
    parameter int VB_DEF = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [15:0]     wr_data,
    input  logic            latch,
    output logic            snap_live,
    output logic            raw_s,
    output logic [HB_W-1:0] hb_s,
    output logic [VB_W-1:0] vb_s
);
    import sro_pkg::*;

    logic [HB_W-1:0] hb_q;
    logic [VB_W-1:0] vb_q;
    logic            raw_q;
    logic            snap_q;

    // Live registers: decode the write port.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_q   <= HB_W'(HB_DEF);
            vb_q   <= VB_W'(VB_DEF);
            raw_q  <= 1'b0;
            snap_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_HBLANK: hb_q <= wr_data[HB_W-1:0];
                ADDR_VBLANK: vb_q <= wr_data[VB_W-1:0];
                ADDR_MODE: begin
                    raw_q  <= wr_data[MODE_RAW_BIT];
                    snap_q <= wr_data[MODE_SNAP_BIT];
                end
                default: ;
            endcase
        end
    end

    // Shadow registers: frozen for the duration of a frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_s  <= HB_W'(HB_DEF);
            vb_s  <= VB_W'(VB_DEF);
            raw_s <= 1'b0;
        end else if (latch) begin
            hb_s  <= hb_q;
            vb_s  <= vb_q;
            raw_s <= raw_q;
        end
    end

    assign snap_live = snap_q;
endmodule

// File: rtl/sro_scan.sv
// Scan sequencer: walks lines and blanking, generates frame/line qualifiers
// and the snapshot strobe. Geometry comes from the shadow registers.
// Assumes ARST_CYC >= 1 and WIN_W/WIN_H not larger than COLS/ROWS.
module sro_scan #(
    parameter int COLS     = 1312,
    parameter int ROWS     = 1048,
    parameter int WIN_W    = 1280,
    parameter int WIN_H    = 1024,
    parameter int HB_W     = 11,
    parameter int VB_W     = 11,
    parameter int ARST_CYC = 16,
    parameter int HCW      = 12,
    parameter int RCW      = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            snap_live,
    input  logic            trig,
    input  logic            raw_s,
    input  logic [HB_W-1:0] hb_s,
    input  logic [VB_W-1:0] vb_s,
    output logic            latch,
    output logic            fv,
    output logic            lv,
    output logic            strobe,
    output logic [HCW-1:0]  col,
    output logic [RCW-1:0]  row
);
    import sro_pkg::*;

    scan_st_t       st_q, st_d;
    logic [HCW-1:0] col_q, col_d;
    logic [RCW-1:0] row_q, row_d;
    logic [HCW-1:0] ncols, hb_eff, line_len;
    logic [RCW-1:0] nrows;
    logic           arst_end, row_end, frame_end;

    // Frame geometry selected by the shadowed raw bit.
    always_comb begin
        ncols    = raw_s ? HCW'(COLS) : HCW'(WIN_W);
        nrows    = raw_s ? RCW'(ROWS) : RCW'(WIN_H);
        hb_eff   = (hb_s == '0) ? HCW'(1) : HCW'(hb_s);
        line_len = ncols + hb_eff;
    end

    assign arst_end  = (st_q == ST_ARST) && (col_q == HCW'(ARST_CYC - 1));
    assign row_end   = (col_q == line_len - HCW'(1));
    assign frame_end = (row_q == nrows - RCW'(1)) && (col_q == ncols - HCW'(1));

    // Next-state and counter update rules.
    always_comb begin
        st_d  = st_q;
        col_d = col_q;
        row_d = row_q;
        case (st_q)
            ST_IDLE: begin
                if (!snap_live) st_d = ST_LEAD;
                else if (trig) begin
                    st_d  = ST_ARST;
                    col_d = '0;
                end
            end
            ST_ARST: begin
                col_d = col_q + HCW'(1);
                if (arst_end) st_d = ST_LEAD;
            end
            ST_LEAD: begin
                st_d  = ST_ROW;
                col_d = '0;
                row_d = '0;
            end
            ST_ROW: begin
                if (frame_end) st_d = ST_TAIL;
                else if (row_end) begin
                    col_d = '0;
                    row_d = row_q + RCW'(1);
                end else col_d = col_q + HCW'(1);
            end
            ST_TAIL: begin
                col_d = '0;
                row_d = '0;
                st_d  = (vb_s == '0) ? ST_IDLE : ST_VBL;
            end
            ST_VBL: begin
                if (row_end) begin
                    col_d = '0;
                    row_d = row_q + RCW'(1);
                    if (row_q == RCW'(vb_s - 1'b1)) st_d = ST_IDLE;
                end else col_d = col_q + HCW'(1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            col_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            col_q <= col_d;
            row_q <= row_d;
        end
    end

    assign latch  = (st_d == ST_LEAD) && (st_q != ST_LEAD);
    assign fv     = (st_q == ST_LEAD) || (st_q == ST_ROW) || (st_q == ST_TAIL);
    assign lv     = (st_q == ST_ROW) && (col_q < ncols);
    assign strobe = arst_end;
    assign col    = col_q;
    assign row    = row_q;

    AST_LV_IN_FV: assert property (@(posedge clk) disable iff (!rst_n)
        lv |-> fv);                                               // R7
    AST_FV_LEADS_LV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv) |-> $past(fv));                                 // R7
    AST_FV_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fv) |-> !$past(lv));                                // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);                                      // R9
    AST_STROBE_THEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (fv && !lv));                                  // R9
    AST_GEOM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ROW) |-> ($stable(raw_s) && $stable(hb_s)));  // R8
    AST_COL_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ROW) |-> (col_q < line_len));                 // R5
endmodule

// File: rtl/sro_pattern.sv
// Synthetic pixel source: maps the scan position to a physical coordinate
// and returns the black code on the border, else (row + col) mod 2^DW.
// Assumes DW <= 16 and array dimensions below 2^15.
module sro_pattern #(
    parameter int COLS       = 1312,
    parameter int ROWS       = 1048,
    parameter int BLK_L      = 16,
    parameter int BLK_T      = 8,
    parameter int BLK_R      = 7,
    parameter int BLK_B      = 7,
    parameter int BORDER     = 4,
    parameter int DW         = 10,
    parameter int BLACK_CODE = 42,
    parameter int HCW        = 12,
    parameter int RCW        = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lv,
    input  logic           raw,
    input  logic [HCW-1:0] col,
    input  logic [RCW-1:0] row,
    output logic [DW-1:0]  dout
);
    localparam int AW = 16;

    logic [AW-1:0] pc, pr, sum;
    logic          black;

    // Physical coordinate and border classification.
    always_comb begin
        pc    = raw ? AW'(col) : AW'(col) + AW'(BLK_L + BORDER);
        pr    = raw ? AW'(row) : AW'(row) + AW'(BLK_T + BORDER);
        black = (pc < AW'(BLK_L)) || (pc >= AW'(COLS - BLK_R)) ||
                (pr < AW'(BLK_T)) || (pr >= AW'(ROWS - BLK_B));
        sum   = pc + pr;
        dout  = !lv ? '0 : (black ? DW'(BLACK_CODE) : sum[DW-1:0]);
    end

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lv |-> (dout == '0));                                    // R4
endmodule

// File: rtl/img_readout_gen.sv
// Top level of the image readout generator: registers, scan sequencer,
// pattern source and output drivers with a common high-impedance release.
// Assumes clk is the master clock; pixel_clk is a gated copy of it.
module img_readout_gen #(
    parameter int COLS       = 1312,
    parameter int ROWS       = 1048,
    parameter int BLK_L      = 16,
    parameter int BLK_T      = 8,
    parameter int BLK_R      = 7,
    parameter int BLK_B      = 7,
    parameter int BORDER     = 4,
    parameter int WIN_W      = 1280,
    parameter int WIN_H      = 1024,
    parameter int HB_W       = 11,
    parameter int VB_W       = 11,
    parameter int HB_DEF     = 32,
    parameter int VB_DEF     = 25,
    parameter int ARST_CYC   = 16,
    parameter int DW         = 10,
    parameter int BLACK_CODE = 42
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          out_dis,
    input  logic          trig,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [15:0]   wr_data,
    output logic          pixel_clk,
    output logic [DW-1:0] pixel_data,
    output logic          frame_act,
    output logic          line_act,
    output logic          expo_strobe
);
    localparam int HCW = $clog2(COLS + (2 ** HB_W) + ARST_CYC + 1);
    localparam int RCW = $clog2(ROWS + (2 ** VB_W) + 1);

    logic            snap_live, raw_s, latch, fv, lv, strobe;
    logic [HB_W-1:0] hb_s;
    logic [VB_W-1:0] vb_s;
    logic [HCW-1:0]  col;
    logic [RCW-1:0]  row;
    logic [DW-1:0]   dout;

    sro_regs #(.HB_W(HB_W), .VB_W(VB_W), .HB_DEF(HB_DEF), .VB_DEF(VB_DEF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .latch(latch), .snap_live(snap_live),
        .raw_s(raw_s), .hb_s(hb_s), .vb_s(vb_s)
    );

    sro_scan #(.COLS(COLS), .ROWS(ROWS), .WIN_W(WIN_W), .WIN_H(WIN_H),
               .HB_W(HB_W), .VB_W(VB_W), .ARST_CYC(ARST_CYC),
               .HCW(HCW), .RCW(RCW)) u_scan (
        .clk(clk), .rst_n(rst_n), .snap_live(snap_live), .trig(trig),
        .raw_s(raw_s), .hb_s(hb_s), .vb_s(vb_s), .latch(latch),
        .fv(fv), .lv(lv), .strobe(strobe), .col(col), .row(row)
    );

    sro_pattern #(.COLS(COLS), .ROWS(ROWS), .BLK_L(BLK_L), .BLK_T(BLK_T),
                  .BLK_R(BLK_R), .BLK_B(BLK_B), .BORDER(BORDER), .DW(DW),
                  .BLACK_CODE(BLACK_CODE), .HCW(HCW), .RCW(RCW)) u_pat (
        .clk(clk), .rst_n(rst_n), .lv(lv), .raw(raw_s),
        .col(col), .row(row), .dout(dout)
    );

    // Output drivers: released together when out_dis is high.
    assign pixel_clk   = out_dis ? 1'bz : clk;
    assign pixel_data  = out_dis ? {DW{1'bz}} : dout;
    assign frame_act   = out_dis ? 1'bz : fv;
    assign line_act    = out_dis ? 1'bz : lv;
    assign expo_strobe = out_dis ? 1'bz : strobe;
endmodule

// File: tb/img_readout_gen_tb_top.sv
module img_readout_gen_tb_top;
    localparam int COLS = 40, ROWS = 24, BL = 4, BT = 2, BR = 3, BB = 3;
    localparam int BORDER = 2, WIN_W = 28, WIN_H = 14;
    localparam int HB_DEF = 5, VB_DEF = 2, ARST = 6, BLACK = 42;

    logic clk = 1'b0, rst_n = 1'b0, out_dis = 1'b0, trig = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    wire         pixel_clk, frame_act, line_act, expo_strobe;
    wire  [9:0]  pixel_data;

    img_readout_gen #(.COLS(COLS), .ROWS(ROWS), .BLK_L(BL), .BLK_T(BT),
        .BLK_R(BR), .BLK_B(BB), .BORDER(BORDER), .WIN_W(WIN_W), .WIN_H(WIN_H),
        .HB_W(6), .VB_W(4), .HB_DEF(HB_DEF), .VB_DEF(VB_DEF),
        .ARST_CYC(ARST), .DW(10), .BLACK_CODE(BLACK)) dut_i (
        .clk(clk), .rst_n(rst_n), .out_dis(out_dis), .trig(trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pixel_clk(pixel_clk), .pixel_data(pixel_data), .frame_act(frame_act),
        .line_act(line_act), .expo_strobe(expo_strobe));

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0, mon_en = 0, cont = 1, have_prev = 0;
    int frames = 0;
    int pend_raw = 0, pend_hb = HB_DEF, pend_vb = VB_DEF;
    int cur_raw = 0, cur_hb = HB_DEF, cur_vb = VB_DEF;
    int line = 0, pix = 0, lowrun = 0, gap = 0;
    logic p_fv = 0, p_lv = 0;

    function automatic int ncols(int raw); return raw ? COLS : WIN_W; endfunction
    function automatic int nrows(int raw); return raw ? ROWS : WIN_H; endfunction
    function automatic int hbe(int hb); return (hb == 0) ? 1 : hb; endfunction
    function automatic int exp_pix(int r, int c);
        if (c < BL || c >= COLS - BR || r < BT || r >= ROWS - BB) return BLACK;
        return (r + c) % 1024;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Monitor: frame structure and pixel values against the register settings.
    always @(negedge clk) begin
        if (mon_en) begin
            if (frame_act && !p_fv) begin
                if (have_prev && cont)
                    chk(gap == cur_vb * (ncols(cur_raw) + hbe(cur_hb)) + 1, "R6 vblank gap",
                        gap, cur_vb * (ncols(cur_raw) + hbe(cur_hb)) + 1);
                have_prev = 1;
                cur_raw = pend_raw; cur_hb = pend_hb; cur_vb = pend_vb;
                line = 0; pix = 0; lowrun = 0;
                chk(line_act == 1'b0, "R7 lead cycle", int'(line_act), 0);
                frames++;
            end
            if (frame_act) begin
                if (line_act) begin
                    if (!p_lv) begin
                        if (line == 0) chk(lowrun == 1, "R7 lead length", lowrun, 1);
                        else chk(lowrun == hbe(cur_hb), "R5 hblank", lowrun, hbe(cur_hb));
                    end
                    chk(int'(pixel_data) == exp_pix(line + (cur_raw ? 0 : BT + BORDER),
                                                   pix + (cur_raw ? 0 : BL + BORDER)),
                        cur_raw ? "R3/R4 raw pixel" : "R2/R4 window pixel", int'(pixel_data),
                        exp_pix(line + (cur_raw ? 0 : BT + BORDER), pix + (cur_raw ? 0 : BL + BORDER)));
                    pix++;
                    lowrun = 0;
                end else begin
                    if (p_lv) begin
                        chk(pix == ncols(cur_raw), "R2/R3 line width", pix, ncols(cur_raw));
                        line++;
                        pix = 0;
                    end
                    chk(pixel_data == 10'd0, "R4 blank data", int'(pixel_data), 0);
                    lowrun++;
                end
            end else begin
                chk(line_act == 1'b0, "R7 lv outside fv", int'(line_act), 0);
                if (p_fv) begin
                    chk(line == nrows(cur_raw), "R2/R3 line count", line, nrows(cur_raw));
                    chk(lowrun == 1, "R7 tail length", lowrun, 1);
                    gap = 0;
                end
                gap++;
            end
            p_fv = frame_act;
            p_lv = line_act;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frame_start();
        int f0 = frames;
        while (frames == f0) @(negedge clk);
    endtask

    initial begin
        int hb, vb, raw, n, f0;
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(frame_act == 1'b0 && line_act == 1'b0, "R1 reset qualifiers",
            int'(frame_act) + int'(line_act), 0);
        chk(pixel_data == 10'd0, "R1 reset data", int'(pixel_data), 0);
        chk(expo_strobe == 1'b0, "R1 reset strobe", int'(expo_strobe), 0);
        rst_n = 1'b1;
        mon_en = 1;
        // First frame runs on defaults (R1); checked by the monitor.
        wait_frame_start();
        // Random geometry with directed zero-blank corners, written mid-frame (R8).
        for (int i = 0; i < 9; i++) begin
            wait_frame_start();
            repeat (5) @(negedge clk);
            raw = (i == 2 || i == 5) ? 1 : int'($urandom % 2);
            hb  = (i == 0) ? 0 : int'($urandom % 10);
            vb  = (i == 1) ? 0 : int'($urandom % 3);
            wr(8'h05, 16'(hb));
            wr(8'h06, 16'(vb));
            wr(8'h20, 16'(raw << 11));
            pend_raw = raw; pend_hb = hb; pend_vb = vb;
        end
        wait_frame_start();
        wait_frame_start();
        // R9: snapshot mode
        wait_frame_start();
        repeat (5) @(negedge clk);
        cont = 0;
        wr(8'h20, 16'h0010);
        pend_raw = 0;
        while (frame_act === 1'b1) @(negedge clk);
        n = 0;
        repeat (300) begin
            @(negedge clk);
            if (frame_act === 1'b1) n++;
        end
        chk(n == 0, "R9 idle without trigger", n, 0);
        // R10: pixel clock follows clk during blanking
        @(posedge clk); #5;
        chk(pixel_clk === 1'b1, "R10 pixclk high phase", int'(pixel_clk), 1);
        @(negedge clk); #2;
        chk(pixel_clk === 1'b0, "R10 pixclk low phase", int'(pixel_clk), 0);
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        n = 1;
        while (expo_strobe !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == ARST, "R9 trigger to strobe", n, ARST);
        chk(frame_act == 1'b0, "R9 no frame during strobe", int'(frame_act), 0);
        @(negedge clk);
        chk(expo_strobe == 1'b0, "R9 strobe one cycle", int'(expo_strobe), 0);
        chk(frame_act == 1'b1, "R9 frame after strobe", int'(frame_act), 1);
        while (frame_act === 1'b1) @(negedge clk);
        f0 = frames;
        repeat (300) @(negedge clk);
        chk(frames == f0, "R9 single frame per trigger", frames - f0, 0);
        // R11: output release
        mon_en = 0;
        wr(8'h20, 16'h0000);
        while (frame_act !== 1'b1) @(negedge clk);
        out_dis = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #5;
            chk(pixel_clk !== 1'b1, "R11 pixclk released", int'(pixel_clk), 0);
            chk(frame_act !== 1'b1, "R11 fv released", int'(frame_act), 0);
        end
        @(negedge clk);
        out_dis = 1'b0;
        @(posedge clk); #5;
        chk(pixel_clk === 1'b1 && frame_act === 1'b1, "R11 outputs driven again",
            int'(pixel_clk) + int'(frame_act), 2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule